// File: doc/BRIEF.md
# Escalating Window Watchdog Supervisor

This block watches over a microcontroller that proves it is alive by toggling a single trigger bit. After power-on, a warm reset request, a wakeup or a watchdog failure, the supervisor opens a long initialisation window. Any inverting trigger inside that window is accepted. From then on it alternates a closed window and an open window. The controller must invert the bit during the open window. Inverting it during the closed window is an early-write failure. Letting the open window run out is also a failure.

Each failure pulses an active-low reset and pulls the fail-safe output low. It also raises an output-disable flag and increments a four-bit failure counter. Failures escalate in two stages. At a configurable count the supply enable is dropped for a long interval, and the long window then starts again. When the counter reaches fifteen, the supervisor requests forced deep standby and clears the counter. It then waits there for a wakeup request. All durations are counted in ticks of an external millisecond strobe and are set by parameters.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rstN` is low and just after it releases, `resetN`=1, `failSafeN`=1, `supplyEn`=1, `forceStandby`=0, `outDisable`=0 and `failCount`=0. The stored trigger polarity is 0, so the first accepted trigger writes 1.
- R2: In the long window, any valid trigger moves to the closed window. If no valid trigger arrives within `LONG_WIN` ticks, a failure occurs on the `LONG_WIN`-th tick.
- R3: A closed window lasts `CLOSED_WIN` ticks and is followed by an open window of `OPEN_WIN` ticks. A valid trigger in the open window starts a fresh closed window at once.
- R4: A trigger is valid only when `trigWr` is high and `trigVal` differs from the last accepted or early-written value. A write of the same value has no effect.
- R5: A valid trigger at any point of the closed window, including its last tick, is an early-write failure.
- R6: An open window that reaches `OPEN_WIN` ticks without a valid trigger causes a failure.
- R7: On a failure, `resetN` goes low for `RST_PULSE` ticks. In the same cycle `failSafeN` goes low and `outDisable` goes high. A long window starts when `resetN` releases.
- R8: Each failure adds one to `failCount`. A valid trigger clears it to 0, drives `failSafeN` high and `outDisable` low.
- R9: After the reset pulse of the `SUPPLY_FAILS`-th failure (8 by default), `supplyEn` and `resetN` stay low for `SUPPLY_OFF` ticks. A long window follows, and the count is kept.
- R10: The `STANDBY_FAILS`-th failure (15 by default) raises `forceStandby`, drops `supplyEn` and `resetN`, and clears `failCount`. The block stays there until `eventReq`, which starts a long window with `failSafeN` high.
- R11: Outside standby, `eventReq` (warm reset or wakeup) restarts the long window from zero. `failCount` and `failSafeN` are kept.
- R12: Window timers advance only on cycles with `msTick` high. Trigger writes during the reset pulse, the supply-off interval or standby have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| msTick | input | 1 | One-cycle time-base strobe; all windows count these |
| trigWr | input | 1 | Write strobe for the trigger bit |
| trigVal | input | 1 | Trigger bit value written with `trigWr` |
| eventReq | input | 1 | Warm reset or wakeup request; restarts the long window |
| resetN | output | 1 | Active-low reset to the supervised controller |
| failSafeN | output | 1 | Active-low fail-safe indication |
| supplyEn | output | 1 | Enable for the controller supply |
| forceStandby | output | 1 | Request for forced deep standby |
| outDisable | output | 1 | Disables driven loads while a failure is unresolved |
| failCount | output | 4 | Consecutive failure count |

## Verification
The assertions assume that `trigWr` and `eventReq` are single-cycle strobes and that `msTick` is synchronous to `clk`. They also assume that the block leaves standby only through `eventReq`. The directed stimulus changes every input on the falling clock edge and keeps each write strobe to exactly one cycle. Most scenarios hold `msTick` high so that window lengths map directly onto clock cycles. One scenario gates the tick off to show that the timers freeze.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    ST_LONG,
    ST_CLOSED,
    ST_OPEN,
    ST_RSTP,
    ST_SUPOFF,
    ST_STBY
  } wdState_t;

  typedef enum logic [2:0] {
    WIN_LONG,
    WIN_CLOSED,
    WIN_OPEN,
    WIN_RST,
    WIN_OFF
  } winSel_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    winSel_t winSel;
    logic    timerClr;
    logic    bitLoad;
    logic    cntInc;
    logic    cntClr;
    logic    fsAssert;
    logic    fsRelease;
  } wdStrobe_t;

endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int LONG_WIN   = 65,
  parameter int CLOSED_WIN = 6,
  parameter int OPEN_WIN   = 10,
  parameter int RST_PULSE  = 2,
  parameter int SUPPLY_OFF = 200,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             trigWr,
  input  logic             trigVal,
  input  wdStrobe_t        st,
  output logic             timerDone,
  output logic             trigValid,
  output logic [CNT_W-1:0] failCount,
  output logic             failSafeN
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_LIM = maxOf(maxOf(maxOf(LONG_WIN, CLOSED_WIN),
                                       maxOf(OPEN_WIN, RST_PULSE)), SUPPLY_OFF);
  localparam int TW = $clog2(MAX_LIM + 1);

  logic [TW-1:0] timer;
  logic [TW-1:0] limM1;
  logic          lastBit;

  always_comb begin
    case (st.winSel)
      WIN_LONG:   limM1 = TW'(LONG_WIN - 1);
      WIN_CLOSED: limM1 = TW'(CLOSED_WIN - 1);
      WIN_OPEN:   limM1 = TW'(OPEN_WIN - 1);
      WIN_RST:    limM1 = TW'(RST_PULSE - 1);
      default:    limM1 = TW'(SUPPLY_OFF - 1);
    endcase
  end

  assign timerDone = msTick && (timer == limM1);
  assign trigValid = trigWr && (trigVal != lastBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (st.timerClr) begin
      timer <= '0;
    end else if (msTick) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastBit <= 1'b0;
    end else if (st.bitLoad) begin
      lastBit <= trigVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCount <= '0;
    end else if (st.cntClr) begin
      failCount <= '0;
    end else if (st.cntInc) begin
      failCount <= failCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failSafeN <= 1'b1;
    end else if (st.fsAssert) begin
      failSafeN <= 1'b0;
    end else if (st.fsRelease) begin
      failSafeN <= 1'b1;
    end
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W         = 4,
  parameter int SUPPLY_FAILS  = 8,
  parameter int STANDBY_FAILS = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eventReq,
  input  logic             timerDone,
  input  logic             trigValid,
  input  logic [CNT_W-1:0] failCount,
  output wdStrobe_t        st,
  output logic             resetN,
  output logic             supplyEn,
  output logic             forceStandby
);

  localparam logic [CNT_W-1:0] SUP_CNT  = CNT_W'(SUPPLY_FAILS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STANDBY_FAILS - 1);

  wdState_t state;
  wdState_t nxt;
  logic     goFail;
  logic     accept;

  always_comb begin
    nxt    = state;
    st     = '0;
    goFail = 1'b0;
    accept = 1'b0;

    case (state)
      ST_LONG:   st.winSel = WIN_LONG;
      ST_CLOSED: st.winSel = WIN_CLOSED;
      ST_OPEN:   st.winSel = WIN_OPEN;
      ST_RSTP:   st.winSel = WIN_RST;
      default:   st.winSel = WIN_OFF;
    endcase

    if (eventReq) begin
      nxt         = ST_LONG;
      st.timerClr = 1'b1;
      if (state == ST_STBY) st.fsRelease = 1'b1;
    end else begin
      case (state)
        ST_LONG, ST_OPEN: begin
          if (trigValid)      accept = 1'b1;
          else if (timerDone) goFail = 1'b1;
        end
        ST_CLOSED: begin
          if (trigValid) begin
            goFail = 1'b1;
          end else if (timerDone) begin
            nxt         = ST_OPEN;
            st.timerClr = 1'b1;
          end
        end
        ST_RSTP: begin
          if (timerDone) begin
            st.timerClr = 1'b1;
            nxt = (failCount == SUP_CNT) ? ST_SUPOFF : ST_LONG;
          end
        end
        ST_SUPOFF: begin
          if (timerDone) begin
            st.timerClr = 1'b1;
            nxt         = ST_LONG;
          end
        end
        ST_STBY: nxt = ST_STBY;
        default: nxt = ST_LONG;
      endcase

      if (accept) begin
        nxt          = ST_CLOSED;
        st.timerClr  = 1'b1;
        st.bitLoad   = 1'b1;
        st.cntClr    = 1'b1;
        st.fsRelease = 1'b1;
      end

      if (goFail) begin
        st.timerClr = 1'b1;
        st.fsAssert = 1'b1;
        st.bitLoad  = (state == ST_CLOSED);
        if (failCount == LAST_CNT) begin
          nxt       = ST_STBY;
          st.cntClr = 1'b1;
        end else begin
          nxt       = ST_RSTP;
          st.cntInc = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LONG;
    else       state <= nxt;
  end

  assign resetN       = !(state == ST_RSTP || state == ST_SUPOFF || state == ST_STBY);
  assign supplyEn     = !(state == ST_SUPOFF || state == ST_STBY);
  assign forceStandby = (state == ST_STBY);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int LONG_WIN      = 65,
  parameter int CLOSED_WIN    = 6,
  parameter int OPEN_WIN      = 10,
  parameter int RST_PULSE     = 2,
  parameter int SUPPLY_OFF    = 200,
  parameter int SUPPLY_FAILS  = 8,
  parameter int STANDBY_FAILS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       trigWr,
  input  logic       trigVal,
  input  logic       eventReq,
  output logic       resetN,
  output logic       failSafeN,
  output logic       supplyEn,
  output logic       forceStandby,
  output logic       outDisable,
  output logic [3:0] failCount
);

  localparam int CNT_W = 4;

  wdStrobe_t st;
  logic      timerDone;
  logic      trigValid;

  wdog_ctrl #(
    .CNT_W        (CNT_W),
    .SUPPLY_FAILS (SUPPLY_FAILS),
    .STANDBY_FAILS(STANDBY_FAILS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .eventReq    (eventReq),
    .timerDone   (timerDone),
    .trigValid   (trigValid),
    .failCount   (failCount),
    .st          (st),
    .resetN      (resetN),
    .supplyEn    (supplyEn),
    .forceStandby(forceStandby)
  );

  wdog_dp #(
    .LONG_WIN  (LONG_WIN),
    .CLOSED_WIN(CLOSED_WIN),
    .OPEN_WIN  (OPEN_WIN),
    .RST_PULSE (RST_PULSE),
    .SUPPLY_OFF(SUPPLY_OFF),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .msTick   (msTick),
    .trigWr   (trigWr),
    .trigVal  (trigVal),
    .st       (st),
    .timerDone(timerDone),
    .trigValid(trigValid),
    .failCount(failCount),
    .failSafeN(failSafeN)
  );

  assign outDisable = !failSafeN || !resetN;

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int STANDBY_FAILS = 15
) (
  input logic       clk,
  input logic       rstN,
  input logic       resetN,
  input logic       failSafeN,
  input logic       supplyEn,
  input logic       forceStandby,
  input logic       outDisable,
  input logic [3:0] failCount
);

  // R7
  fail_enters_failsafe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetN) |-> !failSafeN);

  // R7
  failsafe_disables_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !failSafeN |-> outDisable);

  // R8
  release_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failSafeN) |-> failCount == 4'd0);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failCount != $past(failCount)) |-> (failCount == 4'($past(failCount) + 4'd1) || failCount == 4'd0));

  // R9
  supply_off_holds_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyEn |-> !resetN);

  // R10
  standby_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceStandby |-> (!supplyEn && !resetN && failCount == 4'd0));

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(failCount) < STANDBY_FAILS);

endmodule

bind wdog_supervisor wdog_supervisor_chk #(.STANDBY_FAILS(STANDBY_FAILS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .resetN      (resetN),
  .failSafeN   (failSafeN),
  .supplyEn    (supplyEn),
  .forceStandby(forceStandby),
  .outDisable  (outDisable),
  .failCount   (failCount)
);

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;

  localparam int LW  = 8;
  localparam int CW  = 3;
  localparam int OW  = 4;
  localparam int RP  = 2;
  localparam int SO  = 5;
  localparam int SF  = 8;
  localparam int STF = 15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b1;
  logic       trigWr = 1'b0;
  logic       trigVal = 1'b0;
  logic       eventReq = 1'b0;
  logic       resetN, failSafeN, supplyEn, forceStandby, outDisable;
  logic [3:0] failCount;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wdog_supervisor #(
    .LONG_WIN(LW), .CLOSED_WIN(CW), .OPEN_WIN(OW), .RST_PULSE(RP),
    .SUPPLY_OFF(SO), .SUPPLY_FAILS(SF), .STANDBY_FAILS(STF)
  ) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .trigWr(trigWr), .trigVal(trigVal),
    .eventReq(eventReq), .resetN(resetN), .failSafeN(failSafeN), .supplyEn(supplyEn),
    .forceStandby(forceStandby), .outDisable(outDisable), .failCount(failCount)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic powerOn();
    @(negedge clk);
    rstN = 1'b0; trigWr = 1'b0; trigVal = 1'b0; eventReq = 1'b0; msTick = 1'b1;
    cycles(3);
    rstN = 1'b1;
  endtask

  task automatic trig(input logic v);
    trigWr = 1'b1; trigVal = v;
    cycles(1);
    trigWr = 1'b0;
  endtask

  task automatic pulseEvent();
    eventReq = 1'b1;
    cycles(1);
    eventReq = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk);
    rstN = 1'b0;
    cycles(2);
    check("R1 resetN in reset", resetN, 1);
    rstN = 1'b1;
    check("R1 failSafeN", failSafeN, 1);
    check("R1 supplyEn", supplyEn, 1);
    check("R1 forceStandby", forceStandby, 0);
    check("R1 outDisable", outDisable, 0);
    check("R1 failCount", failCount, 0);
  endtask

  task automatic tLongWindow();
    powerOn();
    trig(1'b0);
    cycles(LW - 2);
    check("R4 same-polarity write ignored, long still open", resetN, 1);
    cycles(1);
    check("R2 long window expiry fails", resetN, 0);
    check("R2 count after long expiry", failCount, 1);
    powerOn();
    cycles(LW - 2);
    trig(1'b1);
    check("R2 late trigger in long window accepted", resetN, 1);
    cycles(2);
    check("R2 no failure after long trigger", resetN, 1);
  endtask

  task automatic tEarlyWrite();
    powerOn();
    trig(1'b1);
    trig(1'b1);
    check("R4 repeated value in closed window ignored", resetN, 1);
    trig(1'b0);
    check("R5 early write fails", resetN, 0);
    check("R7 failSafeN low on failure", failSafeN, 0);
    check("R7 outDisable high on failure", outDisable, 1);
    powerOn();
    trig(1'b1);
    cycles(CW - 1);
    trig(1'b0);
    check("R5 early write on last closed tick fails", resetN, 0);
  endtask

  task automatic tWindows();
    powerOn();
    trig(1'b1);
    cycles(CW);
    trig(1'b0);
    check("R3 trigger in open window accepted", resetN, 1);
    check("R3 count stays zero", failCount, 0);
    cycles(CW + OW - 1);
    check("R3 new closed+open span not yet over", resetN, 1);
    cycles(1);
    check("R6 open window expiry fails", resetN, 0);
  endtask

  task automatic tCounterClear();
    powerOn();
    cycles(LW);
    check("R7 reset pulse starts", resetN, 0);
    cycles(RP - 1);
    check("R7 reset still low before pulse end", resetN, 0);
    trig(1'b1);
    check("R7 reset released after pulse", resetN, 1);
    check("R12 trigger during reset pulse ignored, failSafeN", failSafeN, 0);
    check("R12 trigger during reset pulse ignored, count", failCount, 1);
    trig(1'b1);
    check("R8 valid trigger clears count", failCount, 0);
    check("R8 valid trigger releases failSafeN", failSafeN, 1);
    check("R8 outDisable released", outDisable, 0);
  endtask

  task automatic tEscalation();
    powerOn();
    cycles(LW);
    for (int i = 1; i <= STF; i++) begin
      if (i == STF) begin
        check("R10 forceStandby at last failure", forceStandby, 1);
        check("R10 supply off in standby", supplyEn, 0);
        check("R10 count cleared in standby", failCount, 0);
      end else begin
        check($sformatf("R8 count after failure %0d", i), failCount, i);
        cycles(RP);
        if (i == SF) begin
          check("R9 supply drops after reset pulse", supplyEn, 0);
          cycles(SO - 1);
          check("R9 supply still off", supplyEn, 0);
          check("R9 reset held during supply off", resetN, 0);
          cycles(1);
          check("R9 supply restored", supplyEn, 1);
          check("R9 count kept", failCount, SF);
        end
        cycles(LW);
      end
    end
    trig(1'b1);
    cycles(10);
    check("R12 standby holds despite trigger", forceStandby, 1);
    check("R10 reset held in standby", resetN, 0);
    pulseEvent();
    check("R10 wake leaves standby", forceStandby, 0);
    check("R10 wake restores supply", supplyEn, 1);
    check("R10 failSafeN inactive after wake", failSafeN, 1);
    cycles(LW - 1);
    check("R10 long window after wake", resetN, 1);
    cycles(1);
    check("R10 failure after wake long window", failSafeN, 0);
  endtask

  task automatic tWarm();
    powerOn();
    cycles(LW);
    cycles(RP);
    cycles(LW - 2);
    pulseEvent();
    check("R11 count kept over warm request", failCount, 1);
    check("R11 failSafeN kept over warm request", failSafeN, 0);
    cycles(LW - 1);
    check("R11 long window restarted", resetN, 1);
    cycles(1);
    check("R11 failure after restarted window", resetN, 0);
    check("R11 count continues", failCount, 2);
  endtask

  task automatic tTickGate();
    powerOn();
    msTick = 1'b0;
    cycles(3 * LW);
    check("R12 no expiry without tick", resetN, 1);
    msTick = 1'b1;
    cycles(LW - 1);
    check("R12 long window counts ticks", resetN, 1);
    cycles(1);
    check("R12 expiry after ticks", resetN, 0);
  endtask

  initial begin
    tReset();
    tLongWindow();
    tEarlyWrite();
    tWindows();
    tCounterClear();
    tEscalation();
    tWarm();
    tTickGate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule